// File: doc/BRIEF.md
# Conditional Branch Resolution Unit

This unit resolves one branch-on-condition instruction per handshake. It takes a decoded 32-bit instruction word, the current 2-bit condition code, the values of the general registers named by the two register fields, and the sequential address that follows the instruction. From these it decides whether the branch is taken and returns the next 24-bit instruction address. A register form and an indexed form are handled. The condition code is only read and is never changed.

The register form is a halfword placed in `instr[31:16]`. The indexed form uses the full word. The register file supplies `opnd_a`, which holds the register named by `instr[19:16]`, and `opnd_b`, which holds the register named by `instr[15:12]`. One register-form encoding is not a jump: it asks for storage serialization. In that case the unit raises `serialize_req` and drops `in_ready`. It stays there until the storage subsystem pulses `drain_done`. Only then does it release a not-taken result.

Top module: `branch_resolve`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `out_valid` and `serialize_req` are 0 and `in_ready` is 1.
- R2: The taken decision uses mask `instr[23:20]`. Condition code 0 selects bit 23, code 1 selects bit 22, code 2 selects bit 21 and code 3 selects bit 20. The branch can be taken only when the selected bit is 1.
- R3: In the register form (`instr[31:24]` = 0x07) with a nonzero register field `instr[19:16]`, the target is `opnd_a[23:0]`.
- R4: In the register form with `instr[19:16]` = 0 and a mask other than 15, the result is never taken.
- R5: In the indexed form (`instr[31:24]` = 0x47), the target is the sum modulo 2^24 of three terms: `opnd_a[23:0]`, `opnd_b[23:0]` and the 12-bit displacement `instr[11:0]`. The `opnd_a` term counts as zero when `instr[19:16]` is 0, and the `opnd_b` term counts as zero when `instr[15:12]` is 0.
- R6: Every result that is not taken carries `seq_addr` as the next address. For an ordinary result this is the value at acceptance; for a serialization result it is the value captured at acceptance.
- R7: A mask of 0 is never taken. A mask of 15 is always taken in the indexed form, and in the register form when the register field is nonzero.
- R8: Accepting `instr[31:16]` = 0x07F0 sets `serialize_req` and clears `in_ready` from the next cycle. Both hold until `drain_done` is seen. The cycle after that, the unit emits one result with `out_taken` = 0 and returns to idle.
- R9: Any other opcode yields a result with `out_taken` = 0, `out_illegal` = 1 and the sequential next address. `out_illegal` is 0 for both branch opcodes.
- R10: An instruction is accepted when `in_valid` and `in_ready` are both 1. Every accepted instruction other than serialization produces exactly one `out_valid` pulse in the next cycle. `in_ready` is 1 whenever no serialization is pending.
- R11: A `drain_done` that arrives while no serialization is pending has no effect. No result appears, and the state stays unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Instruction offered |
| in_ready | output | 1 | Unit can accept an instruction |
| instr | input | 32 | Instruction word; the register form sits in bits 31:16 |
| cc | input | 2 | Current condition code |
| opnd_a | input | 32 | Value of the register named by bits 19:16 |
| opnd_b | input | 32 | Value of the register named by bits 15:12 |
| seq_addr | input | 24 | Updated sequential instruction address |
| drain_done | input | 1 | Pulse: all earlier storage accesses are complete |
| serialize_req | output | 1 | Serialization pending, waiting for drain |
| out_valid | output | 1 | Result pulse |
| out_taken | output | 1 | Branch taken |
| out_next | output | 24 | Next instruction address |
| out_illegal | output | 1 | Opcode was neither branch form |

## Verification
The hardest situation to reach is the serialization wait itself. It requires `drain_done` to arrive late, early, in the same cycle as the acceptance, and while new instructions are still being offered. The stimulus mixes the serializing encoding into a random stream. It keeps `in_valid` asserted with fresh words during the wait and pulses `drain_done` at random, including while idle. The reference model must therefore follow every dropped offer and every ignored drain pulse, cycle by cycle.

// File: rtl/branch_resolve.sv
module branch_resolve #(
  parameter int AW = 24,
  parameter int DW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [31:0]   instr,
  input  logic [1:0]    cc,
  input  logic [31:0]   opnd_a,
  input  logic [31:0]   opnd_b,
  input  logic [AW-1:0] seq_addr,
  input  logic          drain_done,
  output logic          serialize_req,
  output logic          out_valid,
  output logic          out_taken,
  output logic [AW-1:0] out_next,
  output logic          out_illegal
);
  localparam logic [7:0] OP_REG = 8'h07;
  localparam logic [7:0] OP_IDX = 8'h47;

  logic [7:0]    opc;
  logic [3:0]    mask, fld_a, fld_b;
  logic [DW-1:0] disp;
  logic          is_reg, is_idx, hit, take, sync_op, accept, waiting;
  logic [AW-1:0] idx_tgt, tgt, held_seq;

  assign opc   = instr[31:24];
  assign mask  = instr[23:20];
  assign fld_a = instr[19:16];
  assign fld_b = instr[15:12];
  assign disp  = instr[DW-1:0];

  assign is_reg  = opc == OP_REG;
  assign is_idx  = opc == OP_IDX;
  assign hit     = mask[2'd3 - cc];
  assign sync_op = is_reg && (&mask) && fld_a == 4'd0;
  assign take    = hit && (is_idx || (is_reg && fld_a != 4'd0));

  assign idx_tgt = (fld_a != 4'd0 ? opnd_a[AW-1:0] : '0)
                 + (fld_b != 4'd0 ? opnd_b[AW-1:0] : '0)
                 + {{(AW-DW){1'b0}}, disp};
  assign tgt     = is_idx ? idx_tgt : opnd_a[AW-1:0];

  assign in_ready      = !waiting;
  assign serialize_req = waiting;
  assign accept        = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      waiting     <= 1'b0;
      held_seq    <= '0;
      out_valid   <= 1'b0;
      out_taken   <= 1'b0;
      out_next    <= '0;
      out_illegal <= 1'b0;
    end else begin
      out_valid <= 1'b0;
      if (waiting) begin
        if (drain_done) begin
          waiting     <= 1'b0;
          out_valid   <= 1'b1;
          out_taken   <= 1'b0;
          out_next    <= held_seq;
          out_illegal <= 1'b0;
        end
      end else if (accept) begin
        if (sync_op) begin
          waiting  <= 1'b1;
          held_seq <= seq_addr;
        end else begin
          out_valid   <= 1'b1;
          out_taken   <= take;
          out_next    <= take ? tgt : seq_addr;
          out_illegal <= !(is_reg || is_idx);
        end
      end
    end
  end
endmodule

// File: rtl/branch_resolve_chk.sv
module branch_resolve_chk #(
  parameter int AW = 24
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic [31:0]   instr,
  input logic [AW-1:0] seq_addr,
  input logic          drain_done,
  input logic          serialize_req,
  input logic          out_valid,
  input logic          out_taken,
  input logic [AW-1:0] out_next,
  input logic          out_illegal
);
  logic acc_plain;
  assign acc_plain = in_valid && in_ready && instr[31:16] != 16'h07F0;

  assert_ready_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    serialize_req |-> !in_ready);
  assert_wait_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    serialize_req && !drain_done |=> serialize_req && !out_valid);
  assert_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
    serialize_req && drain_done |=> out_valid && !out_taken && !serialize_req);
  assert_illegal_untaken_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_illegal |-> !out_taken);
  assert_one_cycle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    acc_plain |=> out_valid);
  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !serialize_req && !(in_valid && in_ready) |=> !out_valid);
  assert_seq_on_fallthrough_R6: assert property (@(posedge clk) disable iff (!rst_n)
    acc_plain |=> out_taken || out_next == $past(seq_addr));
  assert_mask_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && instr[23:20] == 4'd0 |=> !out_taken);
endmodule

bind branch_resolve branch_resolve_chk #(.AW(AW)) chk_i (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .instr(instr), .seq_addr(seq_addr), .drain_done(drain_done),
  .serialize_req(serialize_req), .out_valid(out_valid), .out_taken(out_taken),
  .out_next(out_next), .out_illegal(out_illegal)
);

// File: tb/branch_resolve_tb_top.sv
module branch_resolve_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] instr = '0;
  logic [1:0]  cc = '0;
  logic [31:0] opnd_a = '0;
  logic [31:0] opnd_b = '0;
  logic [23:0] seq_addr = '0;
  logic        drain_done = 1'b0;
  logic        serialize_req, out_valid, out_taken, out_illegal;
  logic [23:0] out_next;

  always #2 clk = ~clk;

  branch_resolve dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .instr(instr), .cc(cc), .opnd_a(opnd_a), .opnd_b(opnd_b),
    .seq_addr(seq_addr), .drain_done(drain_done), .serialize_req(serialize_req),
    .out_valid(out_valid), .out_taken(out_taken), .out_next(out_next),
    .out_illegal(out_illegal)
  );

  int    total = 0, fails = 0, cycles = 0;
  bit    started = 0, done = 0;
  bit    m_wait = 0, in_reset = 1;
  bit    e_valid = 0, e_taken = 0, e_ill = 0;
  int unsigned e_next = 0, m_seq = 0;
  string r_tag = "R1", v_tag = "R1";

  task automatic check(input bit ok, input string tag, input string what,
                       input int unsigned act, input int unsigned exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // Behavioural reference, advanced once per rising edge
  always @(posedge clk) begin
    cycles++;
    started = 1;
    if (!rst_n) begin
      in_reset = 1; m_wait = 0; e_valid = 0; v_tag = "R1";
    end else begin
      int unsigned opc, msk, f1, f2, sel, sum;
      in_reset = 0;
      e_valid = 0;
      opc = instr[31:24]; msk = instr[23:20]; f1 = instr[19:16]; f2 = instr[15:12];
      sel = (msk >> (3 - cc)) & 1;
      v_tag = "R10";
      if (m_wait) begin
        v_tag = "R8";
        if (drain_done) begin
          m_wait = 0; e_valid = 1; e_taken = 0; e_ill = 0; e_next = m_seq; r_tag = "R8";
        end
      end else if (in_valid) begin
        if (opc == 8'h07 && msk == 15 && f1 == 0) begin
          m_wait = 1; m_seq = seq_addr;
        end else begin
          e_valid = 1; e_ill = 0; e_taken = 0; e_next = seq_addr; r_tag = "R6";
          if (opc == 8'h07) begin
            if (f1 == 0) r_tag = "R4";
            else if (sel == 1) begin
              e_taken = 1; e_next = opnd_a % (1 << 24); r_tag = "R3";
            end
          end else if (opc == 8'h47) begin
            if (sel == 1) begin
              sum = (f1 != 0 ? opnd_a % (1 << 24) : 0) + (f2 != 0 ? opnd_b % (1 << 24) : 0)
                  + instr[11:0];
              e_taken = 1; e_next = sum % (1 << 24); r_tag = "R5";
            end
          end else begin
            e_ill = 1; r_tag = "R9";
          end
          if (msk == 0 || (msk == 15 && e_taken)) r_tag = "R7";
          else if (r_tag == "R6" && sel == 0) r_tag = "R2";
        end
      end else if (drain_done) v_tag = "R11";
    end
  end

  always @(negedge clk) begin
    if (started && !done) begin
      string t;
      t = in_reset ? "R1" : v_tag;
      check(out_valid == e_valid, t, "out_valid", out_valid, e_valid);
      check(in_ready == !m_wait, in_reset ? "R1" : "R10", "in_ready", in_ready, !m_wait);
      check(serialize_req == m_wait, in_reset ? "R1" : "R8", "serialize_req",
            serialize_req, m_wait);
      if (e_valid && out_valid) begin
        check(out_taken == e_taken, r_tag, "out_taken", out_taken, e_taken);
        check(out_next == e_next[23:0], r_tag, "out_next", out_next, e_next);
        check(out_illegal == e_ill, e_ill ? "R9" : r_tag, "out_illegal", out_illegal, e_ill);
      end
    end
  end

  task automatic drive(input bit v, input logic [31:0] w, input logic [1:0] c,
                       input logic [31:0] a, input logic [31:0] b,
                       input logic [23:0] s, input bit dd);
    @(negedge clk); #1;
    in_valid = v; instr = w; cc = c; opnd_a = a; opnd_b = b; seq_addr = s; drain_done = dd;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1 rst_n = 1'b1;
    // R2: cc selects mask bit, CC0 on the heaviest bit
    drive(1, 32'h0781_0000, 2'd0, 32'h00ABCDEF, 0, 24'h100, 0);
    drive(1, 32'h0741_0000, 2'd1, 32'h00123456, 0, 24'h104, 0);
    drive(1, 32'h0721_0000, 2'd1, 32'h00123456, 0, 24'h108, 0);
    // R4: register field zero
    drive(1, 32'h07E0_0000, 2'd0, 32'h00777777, 0, 24'h10C, 0);
    // R5: indexed with wrap and zero fields
    drive(1, 32'h47F1_2FFF, 2'd3, 32'h00FFFFF0, 32'h00000020, 24'h110, 0);
    drive(1, 32'h47F0_2010, 2'd2, 32'hDEADBEEF, 32'h00000100, 24'h114, 0);
    drive(1, 32'h47F0_0ABC, 2'd2, 32'hDEADBEEF, 32'hCAFEF00D, 24'h118, 0);
    // R7: mask 0 and mask 15
    drive(1, 32'h4703_4000, 2'd0, 32'h1, 32'h2, 24'h11C, 0);
    // R9: illegal opcode
    drive(1, 32'h06F1_0000, 2'd0, 32'h00445566, 0, 24'h120, 0);
    // R11: drain pulse while idle
    drive(0, 0, 0, 0, 0, 24'h124, 1);
    // R8: serialization with offers during the wait
    drive(1, 32'h07F0_0000, 2'd0, 0, 0, 24'h200, 1);
    drive(1, 32'h0781_0000, 2'd0, 32'h00999999, 0, 24'h204, 0);
    drive(1, 32'h0781_0000, 2'd0, 32'h00999999, 0, 24'h208, 0);
    drive(0, 0, 0, 0, 0, 24'h20C, 1);
    drive(1, 32'h4780_0004, 2'd0, 0, 0, 24'h210, 0);
    for (int i = 0; i < 4000; i++) begin
      logic [31:0] w;
      int k;
      k = $urandom % 8;
      w = $urandom;
      if (k < 3) w[31:24] = 8'h07;
      else if (k < 6) w[31:24] = 8'h47;
      else if (k == 6) w[31:16] = 16'h07F0;
      if (w[31:24] == 8'h07 && ($urandom % 3 == 0)) w[19:16] = 4'd0;
      drive($urandom % 4 != 0, w, 2'($urandom), $urandom, $urandom, 24'($urandom),
            $urandom % 4 == 0);
    end
    drive(0, 0, 0, 0, 0, 0, 1);
    drive(0, 0, 0, 0, 0, 0, 0);
    @(negedge clk); #1;
    finish_run();
  end

  initial begin
    wait (cycles > 150000);
    fails++; total++;
    $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
    finish_run();
  end
endmodule